// File: doc/BRIEF.md
# Staged Clock Divider Configuration Bank

This block turns a single reference clock into several periodic clock-enable pulses: one for the reference path, one for the PLL feedback path, one for the VCO-output/auxiliary path, one for the converter sample clock and one for a general-purpose timer. Each pulse train comes from a counter whose period is a 10-bit setting. The settings are written through a simple register-write port using 16-bit words. Only the low 10 bits of each word are kept.

Every setting has two copies. Writes land in a staged copy, and the counters run from a live copy. Staged values move to the live copy only when a commit happens, and there are two separate ways to commit. The reference and PLL settings go live together when the PLL slot is written. The VCO, converter and timer settings go live when the operating mode moves into receive or transmit. A counter that is in the middle of a period finishes that period at its old length before it picks up a new setting. Both copies of every setting can be read back.

The reset values suit a 3.6864 MHz crystal, so a part running at that frequency needs no programming. The reference input may run at up to 24.576 MHz from an external source, or up to 12.288 MHz from a crystal.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, both the staged and the live copy of every slot read back the default values: slot 0 (reference) = 3, slot 1 (PLL) = 8, slot 2 (VCO/aux) = 4, slot 3 (converter) = 6, slot 4 (timer) = 10.
- R2: A write to slot 0..4 stores `wr_data[9:0]` in that slot's staged copy on the next clock edge. Bits 15:10 are discarded.
- R3: A write to slot 0 on its own leaves the live reference and PLL values unchanged.
- R4: A write to slot 1 stores its data and, on the same edge, copies the staged slot 0 and slot 1 values into the live copies.
- R5: The live values of slots 2, 3 and 4 change only on an edge where `mode` (00 idle, 01 receive, 10 transmit, 11 treated as idle) holds receive or transmit and differs from its value on the previous edge. Writes to these slots, staying in one mode, and moves into idle do not commit them.
- R6: A live setting N ≥ 1 gives a one-cycle pulse on its `div_en` bit every N clocks. A setting of 0 behaves as divide-by-1, so the bit stays high.
- R7: When a new live setting arrives, the period that is already running keeps its old length, and the new length starts with the following period.
- R8: After reset is released, slot k first pulses after (default_k − 1) rising edges.
- R9: A write to an address of 5..7 changes no stored value. A readback from address 5..7 returns 0.
- R10: `rd_data` shows slot `rd_addr`: the live copy when `rd_live` is 1 and the staged copy when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Slot to write |
| wr_data | input | 16 | Write word; only the low 10 bits are used |
| mode | input | 2 | Operating mode: 00 idle, 01 receive, 10 transmit |
| rd_addr | input | 3 | Slot to read back |
| rd_live | input | 1 | Readback selects the live copy (1) or the staged copy (0) |
| rd_data | output | 10 | Readback value |
| div_en | output | 5 | Clock-enable pulses, one bit per slot |

## Verification
The bench builds the block with its default parameters: 10-bit settings, five slots and the 3.6864 MHz defaults. With short periods of 3 to 10 clocks, the first pulse after reset, steady-state spacing, a reload in the middle of a period and the divide-by-1 case all fit within a few dozen cycles. Because the address field is 3 bits wide, the unused addresses 5 to 7 can be driven, so the bench can check that writes there are ignored and reads there return 0. Setting the converter slot to 0 and committing it through a mode change puts the value-0 corner into the bench.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_RX   = 2'b01,
        MODE_TX   = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    localparam int SLOT_REF  = 0;
    localparam int SLOT_PLL  = 1;
    localparam int SLOT_VCO  = 2;
    localparam int SLOT_CONV = 3;
    localparam int SLOT_TMR  = 4;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int NUM_DIV = 5,
    parameter int DIV_W   = 10,
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 3,
    parameter logic [NUM_DIV*DIV_W-1:0] DEFAULTS = '0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [WORD_W-1:0]                 wr_data,
    input  logic [1:0]                        mode,
    output logic [NUM_DIV-1:0][DIV_W-1:0]     shd_o,
    output logic [NUM_DIV-1:0][DIV_W-1:0]     act_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_DIV - 1);
    localparam logic [ADDR_W-1:0] PLL_ADDR  = ADDR_W'(SLOT_PLL);

    typedef struct packed {
        logic [NUM_DIV-1:0][DIV_W-1:0] shd;
        logic [NUM_DIV-1:0][DIV_W-1:0] act;
        logic [1:0]                    mode;
    } regs_t;

    regs_t q, d;
    logic  pll_commit, mode_commit, is_active_mode;

    always_comb begin
        d              = q;
        d.mode         = mode;
        is_active_mode = (mode == MODE_RX) || (mode == MODE_TX);
        mode_commit    = is_active_mode && (mode != q.mode);
        pll_commit     = wr_en && (wr_addr == PLL_ADDR);

        if (wr_en && (wr_addr <= LAST_ADDR)) begin
            d.shd[wr_addr] = wr_data[DIV_W-1:0];
        end
        if (pll_commit) begin
            d.act[SLOT_REF] = d.shd[SLOT_REF];
            d.act[SLOT_PLL] = d.shd[SLOT_PLL];
        end
        if (mode_commit) begin
            for (int i = SLOT_VCO; i < NUM_DIV; i++) begin
                d.act[i] = d.shd[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.shd  <= DEFAULTS;
            q.act  <= DEFAULTS;
            q.mode <= MODE_IDLE;
        end else begin
            q <= d;
        end
    end

    assign shd_o = q.shd;
    assign act_o = q.act;
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int              DIV_W   = 10,
    parameter logic [DIV_W-1:0] DEF_DIV = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] setting,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] period;
    } cnt_t;

    function automatic logic [DIV_W-1:0] eff(input logic [DIV_W-1:0] v);
        return (v == '0) ? DIV_W'(1) : v;
    endfunction

    cnt_t q, d;

    always_comb begin
        d    = q;
        tick = (q.cnt == q.period - DIV_W'(1));
        if (tick) begin
            d.cnt    = '0;
            d.period = eff(setting);
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt    <= '0;
            q.period <= eff(DEF_DIV);
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int NUM_DIV = 5,
    parameter int DIV_W   = 10,
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 3,
    parameter logic [NUM_DIV*DIV_W-1:0] DEFAULTS =
        {10'd10, 10'd6, 10'd4, 10'd8, 10'd3}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_live,
    output logic [DIV_W-1:0]  rd_data,
    output logic [NUM_DIV-1:0] div_en
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_DIV - 1);

    logic [NUM_DIV-1:0][DIV_W-1:0] shd_vals;
    logic [NUM_DIV-1:0][DIV_W-1:0] act_vals;

    clkdiv_regs #(
        .NUM_DIV (NUM_DIV),
        .DIV_W   (DIV_W),
        .WORD_W  (WORD_W),
        .ADDR_W  (ADDR_W),
        .DEFAULTS(DEFAULTS)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .mode   (mode),
        .shd_o  (shd_vals),
        .act_o  (act_vals)
    );

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        clkdiv_counter #(
            .DIV_W  (DIV_W),
            .DEF_DIV(DEFAULTS[g*DIV_W +: DIV_W])
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .setting(act_vals[g]),
            .tick   (div_en[g])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr <= LAST_ADDR) begin
            rd_data = rd_live ? act_vals[rd_addr] : shd_vals[rd_addr];
        end
    end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
    parameter int NUM_DIV = 5,
    parameter int DIV_W   = 10,
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [WORD_W-1:0]             wr_data,
    input logic [1:0]                    mode,
    input logic [NUM_DIV-1:0][DIV_W-1:0] shd,
    input logic [NUM_DIV-1:0][DIV_W-1:0] act
);
    localparam logic [ADDR_W-1:0] PLL_A  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(NUM_DIV - 1);

    logic [1:0] mode_prev;
    logic       entering;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_prev <= 2'b00;
        else        mode_prev <= mode;
    end
    assign entering = ((mode == 2'b01) || (mode == 2'b10)) && (mode != mode_prev);

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_slot
        assert_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(i)) |=> shd[i] == $past(wr_data[DIV_W-1:0]));
        if (i >= 2) begin : g_mode_grp
            assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !entering |=> $stable(act[i]));
        end
    end

    assert_ref_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == PLL_A) |=> ($stable(act[0]) && $stable(act[1])));

    assert_pll_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PLL_A) |=> (act[0] == shd[0] && act[1] == shd[1]));

    assert_bad_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > LAST_A) |=> $stable(shd));
endmodule

bind clkdiv_bank clkdiv_bank_chk #(
    .NUM_DIV(NUM_DIV),
    .DIV_W  (DIV_W),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .mode   (mode),
    .shd    (shd_vals),
    .act    (act_vals)
);

// File: tb/tb_clkdiv_bank.sv
`timescale 1ns/1ps
module tb_clkdiv_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  mode = 2'b00;
    logic [2:0]  rd_addr = '0;
    logic        rd_live = 1'b0;
    logic [9:0]  rd_data;
    logic [4:0]  div_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int unsigned exp_def [5] = '{3, 8, 4, 6, 10};

    clkdiv_bank dut (.*);

    always #2.5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input int a, input bit live, output int v);
        rd_addr = 3'(a);
        rd_live = live;
        #0.5;
        v = int'(rd_data);
    endtask

    task automatic wr(input int a, input logic [15:0] dat);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode = m;
        @(negedge clk);
    endtask

    task automatic to_pulse(input int idx, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_en[idx] && n < 2000);
    endtask

    task automatic t_reset;
        int v, n;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!div_en[0] && n < 50) begin
            @(negedge clk);
            n++;
        end
        check("R8 first ref pulse edges", n, int'(exp_def[0]) - 1);
        for (int i = 0; i < 5; i++) begin
            rd(i, 1'b0, v); check("R1 staged default", v, int'(exp_def[i]));
            rd(i, 1'b1, v); check("R1 live default", v, int'(exp_def[i]));
        end
    endtask

    task automatic t_periods;
        int n;
        to_pulse(0, n);
        to_pulse(0, n); check("R6 ref period 3", n, 3);
        to_pulse(4, n);
        to_pulse(4, n); check("R6 timer period 10", n, 10);
        to_pulse(1, n);
        to_pulse(1, n); check("R6 pll period 8", n, 8);
    endtask

    task automatic t_stage_ref;
        int v;
        wr(0, 16'hFC07);
        rd(0, 1'b0, v); check("R2 upper bits dropped", v, 7);
        rd(0, 1'b1, v); check("R3 live ref unchanged", v, 3);
        rd(1, 1'b1, v); check("R3 live pll unchanged", v, 8);
        rd(0, 1'b0, v); check("R10 staged readback", v, 7);
    endtask

    task automatic t_commit_pll;
        int v, n;
        to_pulse(0, n);
        wr(1, 16'h8009);
        rd(0, 1'b1, v); check("R4 live ref committed", v, 7);
        rd(1, 1'b1, v); check("R4 live pll committed", v, 9);
        to_pulse(0, n); check("R7 running period keeps old length", n + 1, 3);
        to_pulse(0, n); check("R7 new period length", n, 7);
    endtask

    task automatic t_mode_commit;
        int v;
        wr(2, 16'h0005);
        rd(2, 1'b1, v); check("R5 write alone no commit", v, 4);
        set_mode(2'b00);
        rd(2, 1'b1, v); check("R5 idle stays no commit", v, 4);
        set_mode(2'b01);
        rd(2, 1'b1, v); check("R5 idle->rx commits", v, 5);
        wr(2, 16'h0006);
        set_mode(2'b01);
        rd(2, 1'b1, v); check("R5 rx held no commit", v, 5);
        set_mode(2'b10);
        rd(2, 1'b1, v); check("R5 rx->tx commits", v, 6);
        wr(4, 16'h000C);
        set_mode(2'b00);
        rd(4, 1'b1, v); check("R5 tx->idle no commit", v, 10);
        set_mode(2'b10);
        rd(4, 1'b1, v); check("R5 idle->tx commits timer", v, 12);
    endtask

    task automatic t_div_by_one;
        int n, high;
        wr(3, 16'h0000);
        set_mode(2'b00);
        set_mode(2'b01);
        to_pulse(3, n);
        to_pulse(3, n);
        high = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (div_en[3]) high++;
        end
        check("R6 value 0 is divide-by-1", high, 6);
    endtask

    task automatic t_bad_addr;
        int v;
        wr(5, 16'h0155);
        wr(7, 16'h03FF);
        for (int i = 0; i < 5; i++) begin
            rd(i, 1'b0, v);
            check("R9 staged unchanged", v, (i == 0) ? 7 : (i == 1) ? 9 :
                  (i == 2) ? 6 : (i == 3) ? 0 : 12);
        end
        rd(5, 1'b0, v); check("R9 read addr 5 is 0", v, 0);
        rd(7, 1'b1, v); check("R9 read addr 7 is 0", v, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_periods;
        t_stage_ref;
        t_commit_pll;
        t_mode_commit;
        t_div_by_one;
        t_bad_addr;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule